// File: doc/BRIEF.md
# Ascending Sequential Line Prefetch Detector

This block sits beside a first-level data cache and watches the demand load addresses that flow into it. It turns each byte address into a line number by dropping the byte-within-line bits. It keeps the most recently recorded line. When a new access lands exactly one line above that recorded line, the block asks the second-level cache fill logic to bring in the line two above the new access. For a walk over lines l, l+1 this is line l+3. Descending walks, repeated touches and walks that skip lines never start a request.

The request leaves through a valid/ready pair toward the second-level fill path. The demand side has no ready signal and is taken on every cycle it is valid. If the fill path has not yet taken a request when a newer one is produced, the newer one overwrites it. A request never crosses the 4 KB page of the access that caused it. A request is also dropped if it names the same line as the previous request.

Top module: `seq_line_prefetch`

## Requirements
- R1: A line number is the byte address shifted right by 6 (64-byte lines), so the low 6 address bits never affect any decision.
- R2: After reset no request is pending and no line is recorded; the first access after reset records its line and never produces a request.
- R3: An access to line l+1 when the recorded line is l makes `pfReqValid` high after the next clock edge, with `pfReqLine` = l+3.
- R4: An access whose line is two or more above the recorded line produces no request.
- R5: An access whose line is at or below the recorded line minus one produces no request.
- R6: An access to the recorded line leaves the record unchanged and produces no request, so l, l, l+1 still triggers.
- R7: A trigger whose target's page (line bits above bit 5, i.e. byte address bits above 11) differs from the triggering access's page produces no request. Every access to a new line still updates the record.
- R8: A trigger whose target equals the most recently requested line produces no request.
- R9: While `pfReqValid` is high and `pfReqReady` is low, the request stays valid and `pfReqLine` stays stable unless a new request replaces it. A cycle with valid and ready both high clears the request, unless a new one is loaded in that cycle.
- R10: A steady ascending walk l, l+1, l+2, ... produces exactly one request per new line, each for the new line plus 2, until the page edge.
- R11: Demand accesses are taken every cycle regardless of `pfReqReady`; a trigger while a request is stalled replaces the pending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| accValid | input | 1 | Demand access present this cycle |
| accAddr | input | ADDR_W | Demand byte address |
| pfReqValid | output | 1 | Prefetch request to second-level fill logic pending |
| pfReqLine | output | ADDR_W-6 | Line number to prefetch |
| pfReqReady | input | 1 | Fill logic takes the request this cycle |

## Verification
The bench sweeps every starting line of a 256-line, four-page space against steps of -2 to +3 lines. A design that mixed up descending and strided steps, or that wrapped line 255 to 0, would issue requests for those patterns. Page-edge pairs check that targets lying one or two lines past a page are dropped; a design missing that check would cross the page. Re-touching a walk after a retreat checks the duplicate-target filter, and a stalled fill port checks that the pending line is held and that a newer trigger overwrites it.

// File: rtl/seq_line_prefetch_pkg.sv
package seq_line_prefetch_pkg;

  // Comparison results the datapath hands to the control.
  typedef struct packed {
    logic sameLine;    // incoming line equals recorded line
    logic nextLine;    // incoming line is recorded line + 1 (no wrap)
    logic inPage;      // target stays in the incoming line's page
    logic hitLastReq;  // target equals last requested line
  } cmpFlags_t;

  // Strobes the control drives into the datapath.
  typedef struct packed {
    logic recordLine;  // capture the incoming line
    logic loadReq;     // capture the target as the new request
  } ctrlStrobes_t;

endpackage

// File: rtl/seq_line_prefetch_dp.sv
module seq_line_prefetch_dp
  import seq_line_prefetch_pkg::*;
#(
  parameter int LINE_W      = 26,
  parameter int PAGE_LINE_W = 6,
  parameter int AHEAD       = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LINE_W-1:0] accLine,
  input  ctrlStrobes_t      st,
  output cmpFlags_t         flags,
  output logic [LINE_W-1:0] reqLine
);

  localparam int EXT_W = LINE_W + 1;
  localparam int PAGE_W = EXT_W - PAGE_LINE_W;

  logic [LINE_W-1:0] lastLine;
  logic [LINE_W-1:0] reqLineQ;
  logic [EXT_W-1:0]  accExt;
  logic [EXT_W-1:0]  lastExtInc;
  logic [EXT_W-1:0]  targetExt;
  logic [PAGE_W-1:0] accPage;
  logic [PAGE_W-1:0] targetPage;

  always_comb begin
    accExt     = {1'b0, accLine};
    lastExtInc = {1'b0, lastLine} + EXT_W'(1);
    targetExt  = accExt + EXT_W'(AHEAD);
    accPage    = accExt[EXT_W-1:PAGE_LINE_W];
    targetPage = targetExt[EXT_W-1:PAGE_LINE_W];
    flags.sameLine   = (accLine == lastLine);
    flags.nextLine   = (accExt == lastExtInc);
    flags.inPage     = (targetPage == accPage);
    flags.hitLastReq = (targetExt[LINE_W-1:0] == reqLineQ);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastLine <= '0;
      reqLineQ <= '0;
    end else begin
      if (st.recordLine) lastLine <= accLine;
      if (st.loadReq)    reqLineQ <= targetExt[LINE_W-1:0];
    end
  end

  assign reqLine = reqLineQ;

  // R7
  target_in_page_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.loadReq |=> reqLineQ[LINE_W-1:PAGE_LINE_W] == $past(accLine[LINE_W-1:PAGE_LINE_W]));

  // R8
  fresh_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.loadReq |=> reqLineQ != $past(reqLineQ));

  // R3
  target_ahead_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.loadReq |=> reqLineQ == $past(accLine) + LINE_W'(AHEAD));

endmodule

// File: rtl/seq_line_prefetch_ctrl.sv
module seq_line_prefetch_ctrl
  import seq_line_prefetch_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         accValid,
  input  cmpFlags_t    flags,
  input  logic         pfReady,
  output ctrlStrobes_t st,
  output logic         pfValid
);

  logic seenValid;
  logic reqSeen;
  logic pendValid;
  logic trigger;

  always_comb begin
    st.recordLine = accValid && !(seenValid && flags.sameLine);
    trigger       = accValid && seenValid && flags.nextLine;
    st.loadReq    = trigger && flags.inPage && !(reqSeen && flags.hitLastReq);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seenValid <= 1'b0;
      reqSeen   <= 1'b0;
      pendValid <= 1'b0;
    end else begin
      if (accValid)   seenValid <= 1'b1;
      if (st.loadReq) reqSeen   <= 1'b1;
      if (st.loadReq)                pendValid <= 1'b1;
      else if (pendValid && pfReady) pendValid <= 1'b0;
    end
  end

  assign pfValid = pendValid;

  // R2
  needs_history_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.loadReq |-> seenValid);

  // R9
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    pendValid && !pfReady |=> pendValid);

  // R9
  pend_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    pendValid && pfReady && !st.loadReq |=> !pendValid);

  // R6
  repeat_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    accValid && seenValid && flags.sameLine |-> !st.loadReq && !st.recordLine);

  // R4 R5
  only_next_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.loadReq |-> flags.nextLine);

endmodule

// File: rtl/seq_line_prefetch.sv
module seq_line_prefetch
  import seq_line_prefetch_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_OFF_W = 6,
  parameter int PAGE_OFF_W = 12,
  parameter int AHEAD      = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       accValid,
  input  logic [ADDR_W-1:0]          accAddr,
  output logic                       pfReqValid,
  output logic [ADDR_W-LINE_OFF_W-1:0] pfReqLine,
  input  logic                       pfReqReady
);

  localparam int LINE_W      = ADDR_W - LINE_OFF_W;
  localparam int PAGE_LINE_W = PAGE_OFF_W - LINE_OFF_W;

  logic [LINE_W-1:0]     accLine;
  logic [LINE_OFF_W-1:0] unusedOffset;
  cmpFlags_t             flags;
  ctrlStrobes_t          st;

  // R1: only the line part of the address takes part in any decision
  assign accLine      = accAddr[ADDR_W-1:LINE_OFF_W];
  assign unusedOffset = accAddr[LINE_OFF_W-1:0];

  seq_line_prefetch_dp #(
    .LINE_W(LINE_W), .PAGE_LINE_W(PAGE_LINE_W), .AHEAD(AHEAD)
  ) u_dp (
    .clk(clk), .rstN(rstN), .accLine(accLine), .st(st),
    .flags(flags), .reqLine(pfReqLine)
  );

  seq_line_prefetch_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .accValid(accValid), .flags(flags),
    .pfReady(pfReqReady), .st(st), .pfValid(pfReqValid)
  );

  // R9
  line_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    pfReqValid && !pfReqReady && !st.loadReq |=> $stable(pfReqLine) && pfReqValid);

  // R11
  replace_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.loadReq |=> pfReqValid);

endmodule

// File: tb/seq_line_prefetch_test.sv
module seq_line_prefetch_test;
  localparam int ADDR_W = 14;
  localparam int LW = ADDR_W - 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic accValid = 1'b0;
  logic [ADDR_W-1:0] accAddr = '0;
  logic pfReqValid;
  logic [LW-1:0] pfReqLine;
  logic pfReqReady = 1'b1;

  int nChecks = 0;
  int nFails = 0;

  // model state
  int mLast = 0;
  bit mSeen = 0;
  int mReq = 0;
  bit mReqSeen = 0;

  always #10 clk = ~clk;

  seq_line_prefetch #(.ADDR_W(ADDR_W)) uut (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accAddr(accAddr),
    .pfReqValid(pfReqValid), .pfReqLine(pfReqLine), .pfReqReady(pfReqReady)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic modelReset();
    mLast = 0; mSeen = 0; mReq = 0; mReqSeen = 0;
  endtask

  // model step; returns 1 when a request is expected, target in tgt
  function automatic bit modelAccess(input int line, output int tgt);
    bit ld = 0;
    tgt = line + 2;
    if (!(mSeen && line == mLast)) begin
      if (mSeen && line == mLast + 1 && (tgt >> 6) == (line >> 6) &&
          !(mReqSeen && tgt == mReq)) ld = 1;
      mLast = line;
    end
    mSeen = 1;
    if (ld) begin mReq = tgt; mReqSeen = 1; end
    return ld;
  endfunction

  // one access with pfReqReady high; checks output after the capturing edge
  task automatic doAccess(input int line, input int off, input string tag);
    int tgt;
    bit exp;
    exp = modelAccess(line, tgt);
    accValid = 1'b1;
    accAddr  = ADDR_W'((line << 6) | (off & 63));
    @(negedge clk);
    accValid = 1'b0;
    chk(pfReqValid == exp, tag, int'(pfReqValid), int'(exp));
    if (exp) chk(int'(pfReqLine) == tgt, tag, int'(pfReqLine), tgt);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    accValid = 1'b0;
    pfReqReady = 1'b1;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    modelReset();
    @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    nFails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    doReset();
    // R2: reset state and first access
    chk(pfReqValid == 1'b0, "R2 reset", int'(pfReqValid), 0);
    doAccess(5, 0, "R2 first access");
    doAccess(6, 0, "R3 after first");

    // R1: byte offset in line irrelevant
    doReset();
    doAccess(10, 63, "R1 offset 63");
    doAccess(11, 0, "R1 offset 0");
    chk(int'(pfReqLine) == 13, "R1 target", int'(pfReqLine), 13);

    // R6: repeats
    doReset();
    doAccess(20, 1, "R6 first");
    doAccess(20, 9, "R6 repeat");
    doAccess(21, 5, "R6 then next");

    // R7: page edges (64 lines per page)
    doReset();
    doAccess(62, 0, "R7 62");
    doAccess(63, 0, "R7 63 to 65");
    doAccess(64, 0, "R7 64 to 66");
    doReset();
    doAccess(61, 0, "R7 61");
    doAccess(62, 0, "R7 62 to 64");
    doReset();
    doAccess(60, 0, "R7 60");
    doAccess(61, 0, "R7 61 to 63");

    // R8: retreat then re-walk gives same target
    doReset();
    doAccess(16, 0, "R8 16");
    doAccess(17, 0, "R8 17 to 19");
    doAccess(16, 0, "R8 back 16");
    doAccess(17, 0, "R8 dup 19");

    // R10: steady walk with repeats, across a page edge
    doReset();
    for (int l = 100; l < 140; l++) begin
      doAccess(l, l, "R10 walk");
      doAccess(l, l + 7, "R10 walk repeat");
    end

    // R9 / R11: stalled fill port
    doReset();
    pfReqReady = 1'b0;
    doAccess(30, 0, "R11 30");
    accValid = 1'b1; accAddr = ADDR_W'(31 << 6);
    @(negedge clk);
    accValid = 1'b0;
    chk(pfReqValid && pfReqLine == 33, "R9 pending 33", int'(pfReqLine), 33);
    repeat (3) begin
      @(negedge clk);
      chk(pfReqValid && pfReqLine == 33, "R9 held", int'(pfReqLine), 33);
    end
    accValid = 1'b1; accAddr = ADDR_W'(32 << 6);
    @(negedge clk);
    accValid = 1'b0;
    chk(pfReqValid && pfReqLine == 34, "R11 replaced", int'(pfReqLine), 34);
    pfReqReady = 1'b1;
    @(negedge clk);
    chk(pfReqValid == 1'b0, "R9 accepted", int'(pfReqValid), 0);

    // R3 R4 R5 R6 R7 sweep over all lines and steps
    doReset();
    for (int p = 0; p < 256; p++) begin
      for (int d = -2; d <= 3; d++) begin
        int c;
        string tag;
        c = (p + d) & 255;
        if (d == 0) tag = "R6 sweep";
        else if (d < 0) tag = "R5 sweep";
        else if (d > 1) tag = "R4 sweep";
        else if (((c + 2) >> 6) != (c >> 6)) tag = "R7 sweep";
        else tag = "R3 sweep";
        doAccess(p, p * 7, tag);
        doAccess(c, p * 3, tag);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule